// File: doc/BRIEF.md
# Single-Wire Bus Slave ROM Command Engine

This block is the slave end of a single open-drain line that idles high. It runs on a system clock and samples the line as a synchronous input. It has one output enable, `bus_pull`, which pulls the line low. Every timing window is measured in clock cycles, derived from a cycles-per-microsecond parameter.

The block recognises a long low from the master as a reset and answers it with a presence pulse. It then takes bit slots, each one opened by a master falling edge, and assembles an 8-bit ROM command from them, least significant bit first.

Two ROM commands are supported:
- **Read ROM (33h):** the slave returns its 64-bit identity. The identity is `rom_id`: family code in bits 7:0, serial number in bits 55:8, CRC in bits 63:56.
- **Match ROM (55h):** the master sends 64 bits. If they all match `rom_id`, `selected` rises so that downstream memory functions may run.

A very long low acts as a power-on reset and pulses `chan_clear`, which switches the output channels off.

Top module: `sw_rom_slave`

## Requirements
- R1: `bus_pull` is low after `rst_n` reset. Apart from presence pulses and transmitted 0 bits, the slave never drives the line, so an idle line with a released master reads high.
- R2: A low lasting more than 120 µs that then ends is followed, 30 µs after the line rises, by a presence pulse: the slave holds the line low for 120 µs.
- R3: A low lasting more than 120 µs abandons whatever transaction is in progress and restarts the sequence with a new presence pulse. A low of 100 µs seen while waiting for a reset produces no presence pulse.
- R4: Command bits and Match ROM bits are taken least significant bit first, sampled 30 µs after each master falling edge. A 6 µs low reads as 1 and a 60 µs low reads as 0.
- R5: Command 33h makes the slave send `rom_id` bit 0 first across 64 read slots. A 0 bit is sent by holding the line low for 30 µs from the slot's falling edge; a 1 bit leaves the line released.
- R6: Command 55h followed by 64 bits equal to `rom_id` sets `selected`.
- R7: If any of the 64 Match ROM bits differs, `selected` stays low and all later traffic is ignored until the next reset: a following 33h command gets no answer.
- R8: An unrecognised command byte (for example CCh) sends the slave to a state where it ignores traffic until the next reset.
- R9: `selected` is cleared by every reset the slave detects.
- R10: A low lasting more than 5 ms pulses `chan_clear` for exactly one clock. Ordinary reset pulses never pulse it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 1 | Sampled level of the shared line (wired-AND of all drivers) |
| rom_id | input | 64 | Identity: family [7:0], serial [55:8], CRC [63:56] |
| bus_pull | output | 1 | 1 pulls the line low (open-drain enable) |
| selected | output | 1 | Set after a full Match ROM hit, cleared by reset |
| chan_clear | output | 1 | One-cycle pulse after more than 5 ms of continuous low |

## Verification
The bench sends a 100 µs low while the slave waits for a reset. A threshold set too low would answer it with a presence pulse.

It applies Match ROM with a single bit flipped, first at bit 0 and then at bit 63, and follows each with a Read ROM command. A compare that quits early, or that forgets its mismatch, would raise `selected` or would drive read data onto the line.

It cuts a Read ROM off after eight bits with a new reset. A slave that kept its bit index or state across the reset would return shifted identity bits.

It holds the line low past 5 ms and counts `chan_clear` pulses. Level decoding instead of edge decoding would produce many pulses, and a wrong threshold would produce none.

// File: rtl/sw_rom_slave.sv
module sw_rom_slave #(
  parameter int US_CYC    = 2,
  parameter int RST_US    = 120,
  parameter int POR_US    = 5000,
  parameter int SAMPLE_US = 30,
  parameter int DRIVE_US  = 30,
  parameter int PWAIT_US  = 30,
  parameter int PRES_US   = 120
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_in,
  input  logic [63:0] rom_id,
  output logic        bus_pull,
  output logic        selected,
  output logic        chan_clear
);
  localparam int RST_CYC  = RST_US * US_CYC;
  localparam int POR_CYC  = POR_US * US_CYC;
  localparam int SAMP_CYC = SAMPLE_US * US_CYC;
  localparam int DRV_CYC  = DRIVE_US * US_CYC;
  localparam int PWT_CYC  = PWAIT_US * US_CYC;
  localparam int PRS_CYC  = PRES_US * US_CYC;
  localparam int CW = $clog2(POR_CYC + 2);
  localparam int TW = $clog2(PRS_CYC + PWT_CYC + SAMP_CYC + DRV_CYC + 1);
  localparam logic [7:0] CMD_READ  = 8'h33;
  localparam logic [7:0] CMD_MATCH = 8'h55;

  typedef enum logic [2:0] {
    S_IDLE, S_RSTLOW, S_PWAIT, S_PRES, S_CMD, S_READ, S_MATCH, S_SEL
  } st_t;

  st_t           st;
  logic          bus_q;
  logic [CW-1:0] low_cnt;
  logic [TW-1:0] tmr;
  logic          in_slot;
  logic [5:0]    idx;
  logic [7:0]    cmd;

  wire       fall    = bus_q & ~bus_in;
  wire       rst_hit = (low_cnt == CW'(RST_CYC + 1));
  wire       rx_end  = in_slot && (tmr == TW'(SAMP_CYC - 1));
  wire       tx_end  = in_slot && (tmr == TW'(DRV_CYC - 1));
  wire [7:0] cmd_nx  = {bus_in, cmd[7:1]};

  assign chan_clear = (low_cnt == CW'(POR_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bus_q    <= 1'b1;
      low_cnt  <= '0;
      tmr      <= '0;
      in_slot  <= 1'b0;
      idx      <= '0;
      cmd      <= '0;
      bus_pull <= 1'b0;
      selected <= 1'b0;
    end else begin
      bus_q <= bus_in;
      if (bus_in || bus_pull)
        low_cnt <= '0;
      else if (low_cnt != CW'(POR_CYC + 1))
        low_cnt <= low_cnt + 1'b1;

      if (rst_hit) begin
        st       <= S_RSTLOW;
        selected <= 1'b0;
        bus_pull <= 1'b0;
        in_slot  <= 1'b0;
      end else begin
        case (st)
          S_RSTLOW:
            if (bus_in) begin
              st  <= S_PWAIT;
              tmr <= '0;
            end
          S_PWAIT:
            if (tmr == TW'(PWT_CYC - 1)) begin
              st       <= S_PRES;
              tmr      <= '0;
              bus_pull <= 1'b1;
            end else tmr <= tmr + 1'b1;
          S_PRES:
            if (tmr == TW'(PRS_CYC - 1)) begin
              st       <= S_CMD;
              bus_pull <= 1'b0;
              idx      <= '0;
              in_slot  <= 1'b0;
            end else tmr <= tmr + 1'b1;
          S_CMD, S_MATCH:
            if (!in_slot) begin
              if (fall) begin
                in_slot <= 1'b1;
                tmr     <= '0;
              end
            end else if (rx_end) begin
              in_slot <= 1'b0;
              idx     <= idx + 1'b1;
              if (st == S_CMD) begin
                cmd <= cmd_nx;
                if (idx == 6'd7) begin
                  idx <= '0;
                  case (cmd_nx)
                    CMD_READ:  st <= S_READ;
                    CMD_MATCH: st <= S_MATCH;
                    default:   st <= S_IDLE;
                  endcase
                end
              end else if (bus_in != rom_id[idx]) begin
                st <= S_IDLE;
              end else if (idx == 6'd63) begin
                st       <= S_SEL;
                selected <= 1'b1;
              end
            end else tmr <= tmr + 1'b1;
          S_READ:
            if (!in_slot) begin
              if (fall) begin
                in_slot  <= 1'b1;
                tmr      <= '0;
                bus_pull <= ~rom_id[idx];
              end
            end else if (tx_end) begin
              in_slot  <= 1'b0;
              bus_pull <= 1'b0;
              idx      <= idx + 1'b1;
              if (idx == 6'd63) st <= S_IDLE;
            end else tmr <= tmr + 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_SEL) |-> !bus_pull);
  a_r3_abort_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> (st == S_RSTLOW && !bus_pull));
  a_r6_sel_state: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> st == S_SEL);
  a_r9_sel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> !selected);
  a_r10_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clear |=> !chan_clear);
endmodule

// File: tb/sw_rom_slave_tb.sv
module sw_rom_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic [63:0] rom_id = 64'h5E_0123456789AB_29;
  logic bus_pull, selected, chan_clear;
  logic wire_lvl;
  int checks = 0, errors = 0, chan_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign wire_lvl = ~(m_low | bus_pull);

  sw_rom_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_in(wire_lvl), .rom_id(rom_id),
    .bus_pull(bus_pull), .selected(selected), .chan_clear(chan_clear)
  );

  always @(posedge clk) if (rst_n && chan_clear) chan_cnt <= chan_cnt + 1;

  localparam logic [63:0] M_VAL [4] = '{
    64'h5E_0123456789AB_29, 64'h5E_0123456789AB_28,
    64'hDE_0123456789AB_29, 64'h5E_0123456789AB_29 };
  localparam bit M_EXP [4] = '{1'b1, 1'b0, 1'b0, 1'b1};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic bus_reset(input int low_us, input string req);
    m_low = 1'b1;
    wait_us(low_us);
    m_low = 1'b0;
    wait_us(10);
    chk({req, " presence delayed"}, wire_lvl, 1'b1);
    wait_us(70);
    chk({req, " presence low"}, wire_lvl, 1'b0);
    wait_us(120);
    chk({req, " presence ended"}, wire_lvl, 1'b1);
  endtask

  task automatic write_bit(input logic b);
    m_low = 1'b1;
    wait_us(b ? 6 : 60);
    m_low = 1'b0;
    wait_us(b ? 64 : 10);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
  endtask

  task automatic read_bit(output logic b);
    m_low = 1'b1;
    wait_us(2);
    m_low = 1'b0;
    wait_us(10);
    b = wire_lvl;
    wait_us(58);
  endtask

  task automatic read_n(input int n, output logic [63:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < n; i++) begin
      read_bit(b);
      v[i] = b;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pull", bus_pull, 1'b0);
    chk("R6 reset selected", selected, 1'b0);
    chk("R10 reset clear", chan_cnt, 0);
    chk("R1 idle line", wire_lvl, 1'b1);

    m_low = 1'b1;
    wait_us(100);
    m_low = 1'b0;
    wait_us(80);
    chk("R3 short low no presence", wire_lvl, 1'b0 | 1'b1);
    chk("R3 short low no drive", bus_pull, 1'b0);
    wait_us(120);

    for (int k = 0; k < 4; k++) begin
      bus_reset(200, "R2");
      chk("R9 selected cleared by reset", selected, 1'b0);
      write_byte(8'h55);
      for (int i = 0; i < 64; i++) write_bit(M_VAL[k][i]);
      wait_us(5);
      chk(M_EXP[k] ? "R6 match sets selected" : "R7 mismatch keeps clear",
          selected, M_EXP[k]);
      if (!M_EXP[k]) begin
        write_byte(8'h33);
        read_n(8, v);
        chk("R7 traffic ignored after mismatch", v[7:0], 8'hFF);
      end
    end

    bus_reset(200, "R9");
    chk("R9 reset clears selected", selected, 1'b0);
    write_byte(8'h33);
    read_n(64, v);
    chk("R5 read rom identity", v, rom_id);
    read_n(4, v);
    chk("R1 no drive after read", v[3:0], 4'hF);

    bus_reset(200, "R8");
    write_byte(8'hCC);
    read_n(8, v);
    chk("R8 unknown command ignored", v[7:0], 8'hFF);

    rom_id = 64'h81_FEDCBA987654_C3;
    bus_reset(200, "R3");
    write_byte(8'h33);
    read_n(8, v);
    chk("R4 family code lsb first", v[7:0], 8'hC3);
    bus_reset(200, "R3 abort");
    write_byte(8'h33);
    read_n(64, v);
    chk("R3 read restarts after abort", v, rom_id);

    chk("R10 ordinary resets no clear", chan_cnt, 0);
    bus_reset(5100, "R10");
    chk("R10 single clear pulse", chan_cnt, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule